// File: doc/BRIEF.md
# Page-Table-Line Snoop CAM for TLB Invalidation

This block sits beside a set-associative TLB and keeps, for every live TLB entry, the physical cache-line address of the leaf page-table entry that the entry was filled from. It is fully associative and is searched by that physical line address, not by virtual page. When the page walker fills a TLB entry, the block records the line address together with a pointer to the TLB set and way. An incoming coherence invalidation, or a committed local store, is compared against every stored line. On a match the block issues invalidate commands for all linked TLB entries in one cycle. This keeps translations coherent with page-table writes, whether the writes come from remote agents or from locally owned lines that produce no coherence traffic.

Addresses are compared at 64-byte line granularity, so several page-table entries in one line share a tag and are invalidated together. An eviction or replacement of a TLB entry clears its link in the same cycle. A fill that collides with a snoop of its own line is dropped and flagged for retry, so a stale translation cannot be recorded. The CAM has as many entries as the TLB. All outputs are registered and appear one cycle after the inputs that cause them.

Top module: `pte_snoop_cam`

## Requirements
- R1: A coherence invalidation (`coh_vld`) whose line matches a stored entry sets `inv_vld` in the next cycle. In the same cycle, bit `set*TLB_WAYS+way` of `inv_tlb_vec` is set for each linked TLB entry.
- R2: Matching ignores address bits [5:0]. Every stored entry in the snooped line is invalidated in the same cycle. A snoop of a line with no stored entry leaves `inv_vld` at 0 and both vectors at 0.
- R3: A matched entry is removed, so a repeat snoop of the same line gives no hit. `inv_vld` and the vectors are one-cycle pulses.
- R4: A local store (`st_vld`, `st_pa`) is compared against the CAM in the same way as a coherence invalidation, with the same outputs.
- R5: A fill with `fill_leaf` = 0, meaning an upper-level table address, is not stored. A later snoop of that line gives no hit.
- R6: An eviction (`evict_vld`, `evict_set`, `evict_way`) clears the entry linked to that set and way, and leaves entries linked to other TLB entries untouched.
- R7: A fill to a set and way that is already linked replaces the old line. The old line no longer hits, and the new line does.
- R8: If a fill's line equals the line of a coherence invalidation or store in the same cycle, the snoop is applied, the fill is not stored, and `fill_retry` is 1 in the next cycle. A fill to any other line gives `fill_retry` = 0 and is stored.
- R9: A coherence invalidation and a store in the same cycle to different lines are both applied. Their hits are reported together in a single pulse.
- R10: A fill takes the lowest-numbered free CAM entry. Bit i of `inv_cam_vec` marks CAM entry i.
- R11: Synchronous `rst` clears every valid bit and drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_vld | input | 1 | TLB fill event |
| fill_leaf | input | 1 | Fill address is a leaf page-table entry |
| fill_pa | input | PA_W | Physical address of the page-table entry |
| fill_set | input | SET_W | TLB set of the filled entry |
| fill_way | input | WAY_W | TLB way of the filled entry |
| evict_vld | input | 1 | TLB entry evicted |
| evict_set | input | SET_W | Set of the evicted entry |
| evict_way | input | WAY_W | Way of the evicted entry |
| coh_vld | input | 1 | Coherence invalidation received |
| coh_pa | input | PA_W | Invalidated physical address |
| st_vld | input | 1 | Local store committed |
| st_pa | input | PA_W | Store physical address |
| inv_vld | output | 1 | At least one TLB entry to invalidate |
| inv_cam_vec | output | DEPTH | Matching CAM entries |
| inv_tlb_vec | output | DEPTH | TLB entries to invalidate, bit set*TLB_WAYS+way |
| fill_retry | output | 1 | Previous fill was dropped and must be retried |

## Verification
Snoops are applied to single entries, to lines holding several entries that differ only in the low six address bits, and to lines that are not stored. These cases show whether the compare uses the right granularity and reports every match rather than only the first. Local stores and coherence invalidations are each tried alone and together in one cycle, which shows that both sources are searched independently. Fill patterns cover non-leaf fills, evictions, re-fills of the same set and way, and fills that collide with a snoop of their own line in the same cycle. These distinguish correct link clearing and replacement, and correct snoop-over-fill priority, from stale entries that survive.

// File: rtl/pte_snoop_cam_pkg.sv
package pte_snoop_cam_pkg;
  localparam int DEF_PA_W   = 40;
  localparam int DEF_LINE_B = 6;
  localparam int DEF_SETS   = 8;
  localparam int DEF_WAYS   = 4;
endpackage

// File: rtl/pte_snoop_line_match.sv
module pte_snoop_line_match #(
  parameter int DEPTH = 32,
  parameter int TAG_W = 34
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][TAG_W-1:0] tags,
  input  logic                        req_vld,
  input  logic [TAG_W-1:0]            req_tag,
  output logic [DEPTH-1:0]            hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = req_vld && valid[i] && (tags[i] == req_tag);
  end
endmodule

// File: rtl/pte_snoop_ptr_match.sv
module pte_snoop_ptr_match #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic [DEPTH-1:0]            valid,
  input  logic [DEPTH-1:0][IDX_W-1:0] ptrs,
  input  logic                        req_vld,
  input  logic [IDX_W-1:0]            req_ptr,
  output logic [DEPTH-1:0]            hit
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign hit[i] = req_vld && valid[i] && (ptrs[i] == req_ptr);
  end
endmodule

// File: rtl/pte_snoop_first_free.sv
module pte_snoop_first_free #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic [DEPTH-1:0] free,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (free[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/pte_snoop_tlb_map.sv
module pte_snoop_tlb_map #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5
) (
  input  logic [DEPTH-1:0]            hit,
  input  logic [DEPTH-1:0][IDX_W-1:0] ptrs,
  output logic [DEPTH-1:0]            tlb_vec
);
  for (genvar t = 0; t < DEPTH; t++) begin : g_tlb
    logic [DEPTH-1:0] sel;
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      assign sel[i] = hit[i] && (ptrs[i] == IDX_W'(t));
    end
    assign tlb_vec[t] = |sel;
  end
endmodule

// File: rtl/pte_snoop_cam.sv
module pte_snoop_cam
  import pte_snoop_cam_pkg::*;
#(
  parameter int PA_W     = DEF_PA_W,
  parameter int LINE_B   = DEF_LINE_B,
  parameter int TLB_SETS = DEF_SETS,
  parameter int TLB_WAYS = DEF_WAYS,
  localparam int SET_W   = $clog2(TLB_SETS),
  localparam int WAY_W   = $clog2(TLB_WAYS),
  localparam int DEPTH   = TLB_SETS * TLB_WAYS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_vld,
  input  logic             fill_leaf,
  input  logic [PA_W-1:0]  fill_pa,
  input  logic [SET_W-1:0] fill_set,
  input  logic [WAY_W-1:0] fill_way,
  input  logic             evict_vld,
  input  logic [SET_W-1:0] evict_set,
  input  logic [WAY_W-1:0] evict_way,
  input  logic             coh_vld,
  input  logic [PA_W-1:0]  coh_pa,
  input  logic             st_vld,
  input  logic [PA_W-1:0]  st_pa,
  output logic             inv_vld,
  output logic [DEPTH-1:0] inv_cam_vec,
  output logic [DEPTH-1:0] inv_tlb_vec,
  output logic             fill_retry
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int TAG_W = PA_W - LINE_B;

  logic [DEPTH-1:0]            vld_q;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q;
  logic [DEPTH-1:0][IDX_W-1:0] ptr_q;

  logic [TAG_W-1:0] fill_tag, coh_tag, st_tag;
  logic [IDX_W-1:0] fill_ptr, evict_ptr, free_idx;
  logic             fill_req, conflict, fill_go, free_any;
  logic [DEPTH-1:0] hit_coh, hit_st, hit_ev, hit_rep, hit_snp, keep, tlb_vec;

  assign fill_tag  = fill_pa[PA_W-1:LINE_B];
  assign coh_tag   = coh_pa[PA_W-1:LINE_B];
  assign st_tag    = st_pa[PA_W-1:LINE_B];
  assign fill_ptr  = IDX_W'(int'(fill_set) * TLB_WAYS + int'(fill_way));
  assign evict_ptr = IDX_W'(int'(evict_set) * TLB_WAYS + int'(evict_way));

  // snoop wins over a fill of the same line
  assign fill_req = fill_vld && fill_leaf;
  assign conflict = fill_req && ((coh_vld && coh_tag == fill_tag) ||
                                 (st_vld && st_tag == fill_tag));
  assign fill_go  = fill_req && !conflict;

  pte_snoop_line_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_coh_match (
    .valid(vld_q), .tags(tag_q), .req_vld(coh_vld), .req_tag(coh_tag), .hit(hit_coh));

  pte_snoop_line_match #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_st_match (
    .valid(vld_q), .tags(tag_q), .req_vld(st_vld), .req_tag(st_tag), .hit(hit_st));

  pte_snoop_ptr_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_ev_match (
    .valid(vld_q), .ptrs(ptr_q), .req_vld(evict_vld), .req_ptr(evict_ptr), .hit(hit_ev));

  pte_snoop_ptr_match #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_rep_match (
    .valid(vld_q), .ptrs(ptr_q), .req_vld(fill_go), .req_ptr(fill_ptr), .hit(hit_rep));

  assign hit_snp = hit_coh | hit_st;
  assign keep    = vld_q & ~hit_snp & ~hit_ev & ~hit_rep;

  pte_snoop_first_free #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_alloc (
    .free(~keep), .any(free_any), .idx(free_idx));

  pte_snoop_tlb_map #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_map (
    .hit(hit_snp), .ptrs(ptr_q), .tlb_vec(tlb_vec));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q       <= '0;
      inv_vld     <= 1'b0;
      inv_cam_vec <= '0;
      inv_tlb_vec <= '0;
      fill_retry  <= 1'b0;
    end else begin
      vld_q <= keep;
      if (fill_go && free_any) vld_q[free_idx] <= 1'b1;
      inv_vld     <= |hit_snp;
      inv_cam_vec <= hit_snp;
      inv_tlb_vec <= tlb_vec;
      fill_retry  <= conflict;
    end
  end

  // payload storage without reset
  always_ff @(posedge clk) begin
    if (fill_go && free_any) begin
      tag_q[free_idx] <= fill_tag;
      ptr_q[free_idx] <= fill_ptr;
    end
  end
endmodule

// File: rtl/pte_snoop_cam_chk.sv
module pte_snoop_cam_chk #(
  parameter int PA_W  = 40,
  parameter int SET_W = 3,
  parameter int WAY_W = 2,
  parameter int DEPTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             fill_vld,
  input logic             fill_leaf,
  input logic [PA_W-1:0]  fill_pa,
  input logic             coh_vld,
  input logic [PA_W-1:0]  coh_pa,
  input logic             st_vld,
  input logic [PA_W-1:0]  st_pa,
  input logic             inv_vld,
  input logic [DEPTH-1:0] inv_cam_vec,
  input logic [DEPTH-1:0] inv_tlb_vec,
  input logic             fill_retry
);
  assert_inv_needs_snoop_R1: assert property (@(posedge clk) disable iff (rst)
    inv_vld |-> $past(coh_vld || st_vld));

  assert_vec_agree_R10: assert property (@(posedge clk) disable iff (rst)
    (inv_cam_vec != '0) == (inv_tlb_vec != '0));

  assert_count_agree_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(inv_tlb_vec) == $countones(inv_cam_vec));

  assert_retry_cause_R8: assert property (@(posedge clk) disable iff (rst)
    fill_retry |-> $past(fill_vld && fill_leaf && (coh_vld || st_vld)));

  assert_nonleaf_no_retry_R5: assert property (@(posedge clk) disable iff (rst)
    $past(!fill_leaf) |-> !fill_retry);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!inv_vld && !fill_retry && inv_cam_vec == '0));
endmodule

bind pte_snoop_cam pte_snoop_cam_chk #(
  .PA_W(PA_W), .SET_W(SET_W), .WAY_W(WAY_W), .DEPTH(DEPTH)
) i_chk (.*);

// File: tb/test_pte_snoop_cam.sv
module test_pte_snoop_cam;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 40;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fill_vld = 0, fill_leaf = 0, evict_vld = 0, coh_vld = 0, st_vld = 0;
  logic [PA_W-1:0] fill_pa = '0, coh_pa = '0, st_pa = '0;
  logic [2:0] fill_set = '0, evict_set = '0;
  logic [1:0] fill_way = '0, evict_way = '0;
  logic inv_vld, fill_retry;
  logic [N-1:0] inv_cam_vec, inv_tlb_vec;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pte_snoop_cam i_pte_snoop_cam (.*);

  function automatic logic [N-1:0] tb(int s, int w);
    return N'(1) << (s * 4 + w);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    fill_vld = 0; fill_leaf = 0; evict_vld = 0; coh_vld = 0; st_vld = 0;
  endtask

  task automatic do_reset();
    rst = 1; tick(); tick(); rst = 0;
  endtask

  task automatic fill(int s, int w, logic [PA_W-1:0] pa, bit leaf = 1);
    fill_vld = 1; fill_leaf = leaf; fill_set = 3'(s); fill_way = 2'(w); fill_pa = pa;
    tick();
  endtask

  task automatic coh(logic [PA_W-1:0] pa);
    coh_vld = 1; coh_pa = pa; tick();
  endtask

  task automatic st(logic [PA_W-1:0] pa);
    st_vld = 1; st_pa = pa; tick();
  endtask

  task automatic evict(int s, int w);
    evict_vld = 1; evict_set = 3'(s); evict_way = 2'(w); tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11 inv_vld after reset", inv_vld, 0);
    chk("R11 retry after reset", fill_retry, 0);
    fill(1, 1, 40'h1000);
    do_reset();
    coh(40'h1000);
    chk("R11 entry cleared by reset", inv_vld, 0);
  endtask

  task automatic t_coh_basic();
    do_reset();
    fill(2, 1, 40'h5_0008);
    coh(40'h5_0030);
    chk("R1 inv_vld", inv_vld, 1);
    chk("R1 tlb vec", inv_tlb_vec, tb(2, 1));
    chk("R10 cam vec lowest entry", inv_cam_vec, 1);
    tick();
    chk("R3 pulse ends", inv_vld, 0);
    coh(40'h5_0000);
    chk("R3 repeat snoop no hit", inv_vld, 0);
  endtask

  task automatic t_line_share();
    do_reset();
    fill(1, 0, 40'h7_0040);
    fill(3, 2, 40'h7_007f);
    fill(4, 3, 40'h7_0080);
    coh(40'h7_00c0);
    chk("R2 other line no hit", inv_vld, 0);
    chk("R2 other line vec", inv_tlb_vec, 0);
    coh(40'h7_0050);
    chk("R2 shared line tlb vec", inv_tlb_vec, tb(1, 0) | tb(3, 2));
    chk("R10 shared line cam vec", inv_cam_vec, 32'h3);
    coh(40'h7_0080);
    chk("R2 neighbour line kept", inv_tlb_vec, tb(4, 3));
  endtask

  task automatic t_store();
    do_reset();
    fill(6, 2, 40'h9_1200);
    st(40'h9_1208);
    chk("R4 store hit", inv_vld, 1);
    chk("R4 store tlb vec", inv_tlb_vec, tb(6, 2));
  endtask

  task automatic t_nonleaf();
    do_reset();
    fill(0, 3, 40'hA_0000, 0);
    chk("R5 nonleaf no retry", fill_retry, 0);
    coh(40'hA_0000);
    chk("R5 nonleaf not stored", inv_vld, 0);
  endtask

  task automatic t_evict();
    do_reset();
    fill(5, 0, 40'hB_0000);
    fill(5, 1, 40'hB_0010);
    evict(5, 0);
    coh(40'hB_0000);
    chk("R6 evicted link gone", inv_tlb_vec, tb(5, 1));
  endtask

  task automatic t_replace();
    do_reset();
    fill(7, 3, 40'hC_0000);
    fill(7, 3, 40'hD_0000);
    coh(40'hC_0000);
    chk("R7 old line no hit", inv_vld, 0);
    coh(40'hD_0000);
    chk("R7 new line hit", inv_tlb_vec, tb(7, 3));
  endtask

  task automatic t_conflict();
    do_reset();
    fill(2, 2, 40'hE_0000);
    fill_vld = 1; fill_leaf = 1; fill_set = 3; fill_way = 0; fill_pa = 40'hE_0020;
    coh_vld = 1; coh_pa = 40'hE_0000;
    tick();
    chk("R8 retry flagged", fill_retry, 1);
    chk("R8 snoop applied", inv_tlb_vec, tb(2, 2));
    coh(40'hE_0000);
    chk("R8 dropped fill not stored", inv_vld, 0);
    fill_vld = 1; fill_leaf = 1; fill_set = 3; fill_way = 1; fill_pa = 40'hF_0000;
    st_vld = 1; st_pa = 40'hF_0040;
    tick();
    chk("R8 other line no retry", fill_retry, 0);
    st(40'hF_0000);
    chk("R8 non-conflict fill stored", inv_tlb_vec, tb(3, 1));
  endtask

  task automatic t_dual();
    do_reset();
    fill(0, 0, 40'h2_0000);
    fill(1, 1, 40'h3_0000);
    fill(2, 0, 40'h4_0000);
    coh_vld = 1; coh_pa = 40'h2_0000;
    st_vld = 1; st_pa = 40'h3_0000;
    tick();
    chk("R9 both sources applied", inv_tlb_vec, tb(0, 0) | tb(1, 1));
    chk("R9 cam vec", inv_cam_vec, 32'h3);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_coh_basic();
    t_line_share();
    t_store();
    t_nonleaf();
    t_evict();
    t_replace();
    t_conflict();
    t_dual();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule